// File: doc/BRIEF.md
# Transmit Stall Watchdog

This block watches a transmit path at a slow periodic tick and decides whether the path has wedged. On every accepted tick it compares four free-running counters with the values it stored at the previous tick. The counters are frames sent, pause frames received, transmit start-of-packet events, and frames delivered by the upstream stage. From that comparison it reports one of three verdicts: all is well, drop transmit-enable for one clock, or ask the surrounding logic for a full MAC reset.

Toggle attempts are counted. When stalls keep coming, the watchdog escalates from toggling to a reset request. The reset sequence itself and the counter sources live outside the block.

The controller has three phases. `PH_WAIT` accepts ticks. `PH_TXOFF` is one clock with transmit-enable forced low. `PH_RSTREQ` is one clock with the reset request raised. The transitions are:
- `PH_WAIT` to `PH_TXOFF` on a toggle verdict.
- `PH_WAIT` to `PH_RSTREQ` on a reset verdict.
- `PH_TXOFF` back to `PH_WAIT` unconditionally.
- `PH_RSTREQ` back to `PH_WAIT` unconditionally.

A rising edge of the programmed enable input is the arming event.

Top module: `tx_stall_wdog`

## Requirements
- R1: After reset, `status` is 0, `toggle_pulse` and `reset_req` are low, and `txen` equals `tx_on`.
- R2: If the frames-sent or pause count differs from its stored value at an accepted tick, `status` becomes 0 (no action) and the toggle count is cleared, whatever the other counters show.
- R3: With no frames or pause progress and a nonzero start-of-packet input, an accepted tick gives `status` 0 and leaves the toggle count unchanged.
- R4: With no frames or pause progress and a zero start-of-packet input, the tick is a stall only if the upstream count differs from its stored value and the stored start-of-packet sample was zero. Otherwise `status` is 0 and the toggle count is cleared.
- R5: A stall with toggle count at most `TOGGLE_LIMIT` (default 4) sets `status` to 1. In the following cycle `txen` is low and `toggle_pulse` is high for exactly one clock. Then `txen` returns to `tx_on`, and the count increments.
- R6: A stall with toggle count above `TOGGLE_LIMIT` sets `status` to 2, raises `reset_req` for exactly one clock, and clears the count. With the default this is the sixth consecutive stall.
- R7: At each accepted tick the frames and pause counts are stored. The start-of-packet marker stores "zero" only when that input was examined and found zero; otherwise it stores "nonzero". The upstream count is stored only when examined.
- R8: A rising edge on `tx_on` clears the toggle count and sets `status` to 0. It also stores all four counters as the baseline, with the start-of-packet marker set from whether that input is zero.
- R9: Ticks are ignored while `tx_on` is low, on the arming cycle, and during the one-clock toggle or reset phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_on | input | 1 | Programmed transmit-enable level; its rising edge arms the watchdog |
| tick | input | 1 | Periodic evaluation strobe |
| frames_cnt | input | CNT_W | Frames-sent counter |
| pause_cnt | input | CNT_W | Received pause-frame counter |
| sop_cnt | input | CNT_W | Transmit start-of-packet counter |
| upstream_cnt | input | CNT_W | Upstream delivered/drop counter |
| txen | output | 1 | Transmit enable to the MAC |
| toggle_pulse | output | 1 | One-clock marker of an enable toggle |
| reset_req | output | 1 | One-clock request for a full MAC reset |
| status | output | 2 | Last verdict: 0 none, 1 toggle, 2 reset |

## Verification
The bench drives six back-to-back stalls. It expects five toggles and then a reset, with the count back at zero afterwards. An off-by-one limit would reset one tick early or late.

It checks that a tick following a progress tick or a nonzero start-of-packet sample is never a stall, even with the upstream count moving. A design that stored the raw marker wrongly would toggle there.

Re-arming part way through an escalation must give five fresh toggles. A design that kept the count would reset too early.

A tick held across the toggle clock, and ticks while disabled, must change nothing. A design that evaluated them would double-toggle or act while off.

// File: rtl/txw_pkg.sv
package txw_pkg;
    typedef enum logic [1:0] {
        VERDICT_NONE   = 2'd0,
        VERDICT_TOGGLE = 2'd1,
        VERDICT_RESET  = 2'd2
    } verdict_e;

    typedef enum logic [1:0] {
        PH_WAIT,
        PH_TXOFF,
        PH_RSTREQ
    } phase_e;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_CLEAR,
        CNT_INC
    } cnt_op_e;
endpackage

// File: rtl/txw_judge.sv
module txw_judge import txw_pkg::*; #(
    parameter int CNT_W        = 32,
    parameter int TCW          = 3,
    parameter int TOGGLE_LIMIT = 4
) (
    input  logic [CNT_W-1:0] frames_cnt,
    input  logic [CNT_W-1:0] pause_cnt,
    input  logic [CNT_W-1:0] sop_cnt,
    input  logic [CNT_W-1:0] upstream_cnt,
    input  logic [CNT_W-1:0] prev_frames,
    input  logic [CNT_W-1:0] prev_pause,
    input  logic [CNT_W-1:0] prev_upstream,
    input  logic             prev_sop_zero,
    input  logic [TCW-1:0]   toggle_count,
    output verdict_e         verdict,
    output cnt_op_e          cnt_op,
    output logic             upstream_read,
    output logic             sop_zero_next
);
    logic progress;
    logic sop_idle;
    logic stalled;

    assign progress = (frames_cnt != prev_frames) || (pause_cnt != prev_pause);
    assign sop_idle = (sop_cnt == '0);
    assign stalled  = (upstream_cnt != prev_upstream) && prev_sop_zero;

    always_comb begin
        verdict       = VERDICT_NONE;
        cnt_op        = CNT_CLEAR;
        upstream_read = 1'b0;
        sop_zero_next = 1'b0;
        if (progress) begin
            cnt_op = CNT_CLEAR;
        end else if (!sop_idle) begin
            cnt_op = CNT_HOLD;
        end else begin
            upstream_read = 1'b1;
            sop_zero_next = 1'b1;
            if (stalled) begin
                if (toggle_count > TCW'(TOGGLE_LIMIT)) begin
                    verdict = VERDICT_RESET;
                    cnt_op  = CNT_CLEAR;
                end else begin
                    verdict = VERDICT_TOGGLE;
                    cnt_op  = CNT_INC;
                end
            end
        end
    end
endmodule

// File: rtl/txw_snapshot.sv
module txw_snapshot #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             step,
    input  logic             upstream_read,
    input  logic             sop_zero_next,
    input  logic [CNT_W-1:0] frames_cnt,
    input  logic [CNT_W-1:0] pause_cnt,
    input  logic [CNT_W-1:0] sop_cnt,
    input  logic [CNT_W-1:0] upstream_cnt,
    output logic [CNT_W-1:0] prev_frames,
    output logic [CNT_W-1:0] prev_pause,
    output logic [CNT_W-1:0] prev_upstream,
    output logic             prev_sop_zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_frames   <= '0;
            prev_pause    <= '0;
            prev_upstream <= '0;
            prev_sop_zero <= 1'b0;
        end else if (arm) begin
            prev_frames   <= frames_cnt;
            prev_pause    <= pause_cnt;
            prev_upstream <= upstream_cnt;
            prev_sop_zero <= (sop_cnt == '0);
        end else if (step) begin
            prev_frames   <= frames_cnt;
            prev_pause    <= pause_cnt;
            prev_sop_zero <= sop_zero_next;
            if (upstream_read) begin
                prev_upstream <= upstream_cnt;
            end
        end
    end
endmodule

// File: rtl/txw_escalate.sv
module txw_escalate import txw_pkg::*; #(
    parameter int TCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm,
    input  logic           step,
    input  cnt_op_e        cnt_op,
    output logic [TCW-1:0] toggle_count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            toggle_count <= '0;
        end else if (arm) begin
            toggle_count <= '0;
        end else if (step) begin
            unique case (cnt_op)
                CNT_CLEAR: toggle_count <= '0;
                CNT_INC:   toggle_count <= toggle_count + 1'b1;
                default:   toggle_count <= toggle_count;
            endcase
        end
    end
endmodule

// File: rtl/tx_stall_wdog.sv
module tx_stall_wdog import txw_pkg::*; #(
    parameter int CNT_W        = 32,
    parameter int TOGGLE_LIMIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_on,
    input  logic             tick,
    input  logic [CNT_W-1:0] frames_cnt,
    input  logic [CNT_W-1:0] pause_cnt,
    input  logic [CNT_W-1:0] sop_cnt,
    input  logic [CNT_W-1:0] upstream_cnt,
    output logic             txen,
    output logic             toggle_pulse,
    output logic             reset_req,
    output logic [1:0]       status
);
    localparam int TCW = $clog2(TOGGLE_LIMIT + 2);

    phase_e           phase, phase_nxt;
    logic             tx_on_q;
    logic             arm;
    logic             accept;
    verdict_e         verdict;
    cnt_op_e          cnt_op;
    logic             upstream_read;
    logic             sop_zero_next;
    logic [CNT_W-1:0] prev_frames, prev_pause, prev_upstream;
    logic             prev_sop_zero;
    logic [TCW-1:0]   toggle_count;

    assign arm    = tx_on && !tx_on_q;
    assign accept = tick && tx_on && !arm && (phase == PH_WAIT);

    txw_judge #(.CNT_W(CNT_W), .TCW(TCW), .TOGGLE_LIMIT(TOGGLE_LIMIT)) u_judge (
        .frames_cnt    (frames_cnt),
        .pause_cnt     (pause_cnt),
        .sop_cnt       (sop_cnt),
        .upstream_cnt  (upstream_cnt),
        .prev_frames   (prev_frames),
        .prev_pause    (prev_pause),
        .prev_upstream (prev_upstream),
        .prev_sop_zero (prev_sop_zero),
        .toggle_count  (toggle_count),
        .verdict       (verdict),
        .cnt_op        (cnt_op),
        .upstream_read (upstream_read),
        .sop_zero_next (sop_zero_next)
    );

    txw_snapshot #(.CNT_W(CNT_W)) u_snap (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm           (arm),
        .step          (accept),
        .upstream_read (upstream_read),
        .sop_zero_next (sop_zero_next),
        .frames_cnt    (frames_cnt),
        .pause_cnt     (pause_cnt),
        .sop_cnt       (sop_cnt),
        .upstream_cnt  (upstream_cnt),
        .prev_frames   (prev_frames),
        .prev_pause    (prev_pause),
        .prev_upstream (prev_upstream),
        .prev_sop_zero (prev_sop_zero)
    );

    txw_escalate #(.TCW(TCW)) u_esc (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm          (arm),
        .step         (accept),
        .cnt_op       (cnt_op),
        .toggle_count (toggle_count)
    );

    // State register, arming edge detector and verdict register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= PH_WAIT;
            tx_on_q <= 1'b0;
            status  <= 2'd0;
        end else begin
            phase   <= phase_nxt;
            tx_on_q <= tx_on;
            if (arm) begin
                status <= 2'd0;
            end else if (accept) begin
                status <= verdict;
            end
        end
    end

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_WAIT: begin
                if (accept && verdict == VERDICT_TOGGLE) begin
                    phase_nxt = PH_TXOFF;
                end else if (accept && verdict == VERDICT_RESET) begin
                    phase_nxt = PH_RSTREQ;
                end
            end
            PH_TXOFF:  phase_nxt = PH_WAIT;
            PH_RSTREQ: phase_nxt = PH_WAIT;
            default:   phase_nxt = PH_WAIT;
        endcase
    end

    // Outputs decoded from the phase
    always_comb begin
        txen         = tx_on;
        toggle_pulse = 1'b0;
        reset_req    = 1'b0;
        unique case (phase)
            PH_TXOFF: begin
                txen         = 1'b0;
                toggle_pulse = 1'b1;
            end
            PH_RSTREQ: reset_req = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tx_stall_wdog_chk.sv
module tx_stall_wdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_on,
    input logic       txen,
    input logic       toggle_pulse,
    input logic       reset_req,
    input logic [1:0] status
);
    p_txen_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_pulse |-> !txen);
    p_toggle_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_pulse |=> !toggle_pulse);
    p_toggle_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_pulse |-> status == 2'd1);
    p_reset_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);
    p_reset_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> status == 2'd2);
    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({toggle_pulse, reset_req}));
    p_off_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |=> $stable(status));
    p_idle_txen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !toggle_pulse |-> txen == tx_on);
    p_status_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd3);
endmodule

bind tx_stall_wdog tx_stall_wdog_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_on        (tx_on),
    .txen         (txen),
    .toggle_pulse (toggle_pulse),
    .reset_req    (reset_req),
    .status       (status)
);

// File: tb/tx_stall_wdog_test.sv
module tx_stall_wdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_on = 1'b0;
    logic        tick = 1'b0;
    logic [31:0] frames_cnt = '0, pause_cnt = '0, sop_cnt = '0, upstream_cnt = '0;
    logic        txen, toggle_pulse, reset_req;
    logic [1:0]  status;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tx_stall_wdog uut (
        .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .tick(tick),
        .frames_cnt(frames_cnt), .pause_cnt(pause_cnt),
        .sop_cnt(sop_cnt), .upstream_cnt(upstream_cnt),
        .txen(txen), .toggle_pulse(toggle_pulse),
        .reset_req(reset_req), .status(status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cnt(input int f, input int p, input int s, input int d);
        frames_cnt = f; pause_cnt = p; sop_cnt = s; upstream_cnt = d;
    endtask

    // One tick; checks the verdict, the pulse cycle and the restore cycle.
    task automatic tick_expect(input string req, input int f, input int p,
                               input int s, input int d, input int exp);
        @(negedge clk);
        set_cnt(f, p, s, d);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(req, status, exp);
        check(req, toggle_pulse, exp == 1);
        check(req, txen, exp != 1);
        check(req, reset_req, exp == 2);
        @(negedge clk);
        check(req, txen, 1);
        check(req, toggle_pulse, 0);
        check(req, reset_req, 0);
    endtask

    task automatic arm_with(input int f, input int p, input int s, input int d);
        @(negedge clk);
        tx_on = 1'b0;
        @(negedge clk);
        set_cnt(f, p, s, d);
        tx_on = 1'b1;
        @(negedge clk);
        check("R8 arm status", status, 0);
        check("R8 arm txen", txen, 1);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 status", status, 0);
        check("R1 txen", txen, 0);
        check("R1 toggle", toggle_pulse, 0);
        check("R1 reset_req", reset_req, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_off_ignored;
        @(negedge clk);
        set_cnt(5, 5, 0, 9);
        tick = 1'b1;
        @(negedge clk);
        set_cnt(5, 5, 0, 10);
        @(negedge clk);
        tick = 1'b0;
        check("R9 off status", status, 0);
        check("R9 off toggle", toggle_pulse, 0);
        check("R9 off txen", txen, 0);
    endtask

    task automatic t_escalate;
        arm_with(10, 3, 0, 100);
        for (int i = 1; i <= 5; i++) tick_expect("R5 toggle", 10, 3, 0, 100 + i, 1);
        tick_expect("R6 reset after five toggles", 10, 3, 0, 106, 2);
        tick_expect("R6 count cleared", 10, 3, 0, 107, 1);
    endtask

    task automatic t_progress;
        tick_expect("R2 frames progress", 11, 3, 0, 108, 0);
        tick_expect("R7 sop unread marks nonzero", 11, 3, 0, 109, 0);
        tick_expect("R4 stall again", 11, 3, 0, 110, 1);
        tick_expect("R2 pause progress", 11, 4, 0, 111, 0);
    endtask

    task automatic t_sop;
        tick_expect("R7 reprime", 11, 4, 0, 112, 0);
        tick_expect("R3 sop nonzero", 11, 4, 7, 113, 0);
        tick_expect("R7 prev sop nonzero", 11, 4, 0, 114, 0);
        tick_expect("R4 upstream unchanged", 11, 4, 0, 114, 0);
        tick_expect("R4 stall", 11, 4, 0, 115, 1);
    endtask

    task automatic t_rearm;
        tick_expect("R5 build count", 11, 4, 0, 116, 1);
        tick_expect("R5 build count", 11, 4, 0, 117, 1);
        arm_with(11, 4, 0, 200);
        for (int i = 1; i <= 5; i++) tick_expect("R8 count cleared", 11, 4, 0, 200 + i, 1);
        tick_expect("R8 R6 reset", 11, 4, 0, 206, 2);
    endtask

    task automatic t_tick_in_toggle;
        @(negedge clk);
        set_cnt(11, 4, 0, 207);
        tick = 1'b1;
        @(negedge clk);
        check("R9 first tick", status, 1);
        upstream_cnt = 208;
        @(negedge clk);
        tick = 1'b0;
        check("R9 held tick toggle", toggle_pulse, 0);
        check("R9 held tick txen", txen, 1);
        check("R9 held tick status", status, 1);
        tick_expect("R9 next tick", 11, 4, 0, 209, 1);
    endtask

    initial begin
        t_reset();
        t_off_ignored();
        t_escalate();
        t_progress();
        t_sop();
        t_rearm();
        t_tick_in_toggle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule